// File: doc/BRIEF.md
# Command Descriptor List Engine

This block walks a list of commands that the host has placed in shared memory and runs them one after another. Each command occupies four 32-bit words. The host loads a quadword-aligned table address into a pointer register, then writes the number of entries to a start register. The engine reads each entry one word at a time over a plain read request/valid port. It decodes the first word and hands the command to a downstream executor through a valid/ready handshake.

Every entry has its own acknowledge-enable flag. A flagged entry produces a one-cycle acknowledge pulse that carries its channel number. The host can therefore queue many entries and flag only the last one, so that a single acknowledge confirms the whole list. Channel activation and deactivation can take a long time. For these two commands the acknowledge is issued when the executor accepts the command. A separate end-of-execution pulse follows later, when the executor reports that the channel operation has finished.

Top module: `srq_engine`

## Requirements
- R1: The pointer register keeps only write-data bits [31:3], and its readback shows bits [2:0] as zero. The first word of a list is fetched from that 8-byte-aligned address.
- R2: Entry n, word k is read from pointer + 16·n + 4·k, in ascending order. Only one read is outstanding at a time, and each read request lasts exactly one cycle.
- R3: Word 0 holds the opcode in bits [3:0], with 1 = configure, 2 = register read, 3 = bus read, 4 = bus write, 5 = activate and 6 = deactivate. Word 0 also holds the channel in bits [15:8] and the device-wide flag in bit 16. The command is presented with these fields and with words 1..3 packed lowest first into cmd_arg. All of these stay steady until cmd_ready is seen.
- R4: Opcode 0 (no-op) finishes without raising cmd_valid.
- R5: Opcodes 7 to 15 set the err flag. The entry is skipped, with no handoff and no acknowledge. err stays set until the next accepted start.
- R6: When word 0 bit 4 is 1, sack pulses for one cycle in the cycle after the entry finishes, carrying its channel on sack_chan. An entry finishes at its handoff, or at decode for a no-op. When the bit is 0, the entry produces no pulse.
- R7: For activate and deactivate, the acknowledge follows the handoff. A later fin_valid for that channel gives an eoce pulse in the next cycle, with eoce_chan set to that channel.
- R8: A fin_valid for a channel that has no unfinished activate or deactivate is ignored. So is a second fin_valid for the same channel.
- R9: busy rises in the cycle after a start write with a nonzero count, and falls in the cycle after the last entry finishes. A start with count 0, or a start while busy, is ignored.
- R10: When an acknowledge and an end-of-execution fall in the same cycle, both pulses appear together on their own outputs.
- R11: After reset, busy, err, sack, eoce, mem_req and cmd_valid are low and the pointer reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Write strobe for the table pointer |
| ptr_wdata | input | 32 | Table pointer write data |
| ptr_rdata | output | 32 | Table pointer readback, low three bits zero |
| start_we | input | 1 | Start strobe |
| start_cnt | input | CNT_W | Number of entries to run |
| busy | output | 1 | A list is being processed |
| err | output | 1 | Sticky flag for an undefined opcode |
| mem_req | output | 1 | Word read request, one cycle |
| mem_addr | output | 32 | Byte address of the word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_op | output | 4 | Opcode |
| cmd_chan | output | CHAN_W | Target channel |
| cmd_dev | output | 1 | Device-wide command |
| cmd_arg | output | 96 | Words 1..3 of the entry |
| cmd_ready | input | 1 | Executor accepts the command |
| fin_valid | input | 1 | Executor reports a finished channel operation |
| fin_chan | input | CHAN_W | Channel of the finished operation |
| sack | output | 1 | Acknowledge pulse |
| sack_chan | output | CHAN_W | Channel of the acknowledge |
| eoce | output | 1 | End-of-execution pulse |
| eoce_chan | output | CHAN_W | Channel of the end-of-execution |

## Verification
The hardest case to reach is an acknowledge and an end-of-execution pulse landing in the same cycle. This needs an earlier deactivate still unfinished at the exact edge where a later flagged command is handed off. The bench's executor model reaches it by raising cmd_ready for the configure command and fin_valid for the earlier deactivate's channel on the same falling edge. Both are then registered on one rising edge. The other ordering corner is a start write while a slow handoff is pending. The executor holds cmd_ready low for twenty cycles, so the second start lands inside the busy window.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;
    localparam int DESC_WORDS = 4;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_CFG    = 4'd1,
        OP_RDREG  = 4'd2,
        OP_BUSRD  = 4'd3,
        OP_BUSWR  = 4'd4,
        OP_ACT    = 4'd5,
        OP_DEACT  = 4'd6
    } srq_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_WAIT = 3'd2,
        S_DEC  = 3'd3,
        S_EXEC = 3'd4
    } srq_state_e;
endpackage

// File: rtl/srq_base_reg.sv
module srq_base_reg
    import srq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-4:0] hi;
    } base_t;

    base_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (we) r_d.hi = wdata[ADDR_W-1:3];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = {r_q.hi, 3'b000};
endmodule

// File: rtl/srq_decode.sv
module srq_decode
    import srq_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic [WORD_W-1:0] w0,
    output logic [3:0]        op,
    output logic              known,
    output logic              is_nop,
    output logic              is_long,
    output logic              ack_en,
    output logic [CHAN_W-1:0] chan,
    output logic              dev
);
    assign op     = w0[3:0];
    assign ack_en = w0[4];
    assign chan   = w0[8 +: CHAN_W];
    assign dev    = w0[16];

    always_comb begin
        known   = 1'b1;
        is_nop  = 1'b0;
        is_long = 1'b0;
        case (op)
            OP_NOP:                              is_nop  = 1'b1;
            OP_CFG, OP_RDREG, OP_BUSRD, OP_BUSWR: known  = 1'b1;
            OP_ACT, OP_DEACT:                    is_long = 1'b1;
            default:                             known   = 1'b0;
        endcase
    end
endmodule

// File: rtl/srq_eoce_track.sv
module srq_eoce_track #(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [CHAN_W-1:0] set_chan,
    input  logic              fin_valid,
    input  logic [CHAN_W-1:0] fin_chan,
    output logic              eoce,
    output logic [CHAN_W-1:0] eoce_chan
);
    localparam int NCHAN = 1 << CHAN_W;

    typedef struct packed {
        logic [NCHAN-1:0]  pend;
        logic              pulse;
        logic [CHAN_W-1:0] chan;
    } trk_t;

    trk_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (fin_valid && r_q.pend[fin_chan]) begin
            r_d.pend[fin_chan] = 1'b0;
            r_d.pulse          = 1'b1;
            r_d.chan           = fin_chan;
        end
        if (set_valid) r_d.pend[set_chan] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign eoce      = r_q.pulse;
    assign eoce_chan = r_q.chan;

    // R7: an end-of-execution pulse always follows a finish report
    p_eoce_after_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoce |-> $past(fin_valid) && eoce_chan == $past(fin_chan));

    // R8: no two consecutive pulses for one channel from a single report
    p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoce && !$past(fin_valid, 1) |-> 1'b0);
endmodule

// File: rtl/srq_engine.sv
module srq_engine
    import srq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CHAN_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptr_we,
    input  logic [31:0]                   ptr_wdata,
    output logic [31:0]                   ptr_rdata,
    input  logic                          start_we,
    input  logic [CNT_W-1:0]              start_cnt,
    output logic                          busy,
    output logic                          err,
    output logic                          mem_req,
    output logic [31:0]                   mem_addr,
    input  logic                          mem_rvalid,
    input  logic [31:0]                   mem_rdata,
    output logic                          cmd_valid,
    output logic [3:0]                    cmd_op,
    output logic [CHAN_W-1:0]             cmd_chan,
    output logic                          cmd_dev,
    output logic [3*32-1:0]               cmd_arg,
    input  logic                          cmd_ready,
    input  logic                          fin_valid,
    input  logic [CHAN_W-1:0]             fin_chan,
    output logic                          sack,
    output logic [CHAN_W-1:0]             sack_chan,
    output logic                          eoce,
    output logic [CHAN_W-1:0]             eoce_chan
);
    localparam int ARG_W  = (DESC_WORDS - 1) * WORD_W;
    localparam int STRIDE = DESC_WORDS * (WORD_W / 8);
    localparam int IDX_W  = $clog2(DESC_WORDS);

    typedef struct packed {
        srq_state_e                        st;
        logic [ADDR_W-1:0]                 ptr;
        logic [IDX_W-1:0]                  widx;
        logic [CNT_W-1:0]                  remain;
        logic [DESC_WORDS-1:0][WORD_W-1:0] words;
        logic                              err;
        logic                              sack;
        logic [CHAN_W-1:0]                 sack_chan;
    } eng_t;

    eng_t r_q, r_d;

    logic [ADDR_W-1:0] base_addr;
    logic [3:0]        dec_op;
    logic              dec_known, dec_nop, dec_long, dec_ack, dec_dev;
    logic [CHAN_W-1:0] dec_chan;
    logic              done_desc;
    logic              handoff;

    srq_base_reg u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ptr_we),
        .wdata (ptr_wdata),
        .rdata (base_addr)
    );

    srq_decode #(.CHAN_W(CHAN_W)) u_dec (
        .w0      (r_q.words[0]),
        .op      (dec_op),
        .known   (dec_known),
        .is_nop  (dec_nop),
        .is_long (dec_long),
        .ack_en  (dec_ack),
        .chan    (dec_chan),
        .dev     (dec_dev)
    );

    assign handoff = (r_q.st == S_EXEC) && cmd_ready;

    always_comb begin
        r_d       = r_q;
        r_d.sack  = 1'b0;
        done_desc = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_we && start_cnt != '0) begin
                    r_d.st     = S_REQ;
                    r_d.ptr    = base_addr;
                    r_d.widx   = '0;
                    r_d.remain = start_cnt;
                    r_d.err    = 1'b0;
                end
            end
            S_REQ: r_d.st = S_WAIT;
            S_WAIT: begin
                if (mem_rvalid) begin
                    r_d.words[r_q.widx] = mem_rdata;
                    if (r_q.widx == IDX_W'(DESC_WORDS - 1)) begin
                        r_d.st = S_DEC;
                    end else begin
                        r_d.widx = r_q.widx + 1'b1;
                        r_d.st   = S_REQ;
                    end
                end
            end
            S_DEC: begin
                if (!dec_known) begin
                    r_d.err   = 1'b1;
                    done_desc = 1'b1;
                end else if (dec_nop) begin
                    r_d.sack  = dec_ack;
                    done_desc = 1'b1;
                end else begin
                    r_d.st = S_EXEC;
                end
            end
            S_EXEC: begin
                if (cmd_ready) begin
                    r_d.sack  = dec_ack;
                    done_desc = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (done_desc) begin
            r_d.sack_chan = dec_chan;
            r_d.ptr       = r_q.ptr + ADDR_W'(STRIDE);
            r_d.remain    = r_q.remain - 1'b1;
            r_d.widx      = '0;
            r_d.st        = (r_q.remain == CNT_W'(1)) ? S_IDLE : S_REQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    srq_eoce_track #(.CHAN_W(CHAN_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (handoff && dec_long),
        .set_chan  (dec_chan),
        .fin_valid (fin_valid),
        .fin_chan  (fin_chan),
        .eoce      (eoce),
        .eoce_chan (eoce_chan)
    );

    assign ptr_rdata = base_addr;
    assign busy      = (r_q.st != S_IDLE);
    assign err       = r_q.err;
    assign mem_req   = (r_q.st == S_REQ);
    assign mem_addr  = r_q.ptr + {{(ADDR_W-IDX_W-2){1'b0}}, r_q.widx, 2'b00};
    assign cmd_valid = (r_q.st == S_EXEC);
    assign cmd_op    = dec_op;
    assign cmd_chan  = dec_chan;
    assign cmd_dev   = dec_dev;
    assign cmd_arg   = ARG_W'(r_q.words[DESC_WORDS-1:1]);
    assign sack      = r_q.sack;
    assign sack_chan = r_q.sack_chan;

    // R1: the first fetch of a list uses the pointer held at start
    p_first_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req && mem_addr == $past(ptr_rdata));

    // R2: read requests are single-cycle
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3: an offered command holds its fields until accepted
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
                                    && $stable(cmd_chan) && $stable(cmd_arg));

    // R6: acknowledges only come out of an active list
    p_sack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sack |-> $past(busy));

    // R9: an idle engine neither fetches nor offers commands
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !mem_req);
endmodule

// File: tb/tb_srq_engine.sv
module tb_srq_engine;
    localparam int CNT_W  = 8;
    localparam int CHAN_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ptr_we = 1'b0;
    logic [31:0]       ptr_wdata = '0;
    logic [31:0]       ptr_rdata;
    logic              start_we = 1'b0;
    logic [CNT_W-1:0]  start_cnt = '0;
    logic              busy, err, mem_req;
    logic [31:0]       mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              cmd_valid;
    logic [3:0]        cmd_op;
    logic [CHAN_W-1:0] cmd_chan;
    logic              cmd_dev;
    logic [95:0]       cmd_arg;
    logic              cmd_ready = 1'b0;
    logic              fin_valid = 1'b0;
    logic [CHAN_W-1:0] fin_chan = '0;
    logic              sack, eoce;
    logic [CHAN_W-1:0] sack_chan, eoce_chan;

    always #5 clk = ~clk;

    srq_engine #(.CNT_W(CNT_W), .CHAN_W(CHAN_W)) dut (.*);

    logic [31:0] mem [0:255];
    int n_checks = 0, n_fail = 0;
    int ncyc = 0;
    // environment logs
    int hoff_n, sack_n, eoce_n, both_n, addr_n;
    logic [3:0]  hoff_op [0:15];
    logic [7:0]  hoff_chan [0:15];
    logic        hoff_dev [0:15];
    logic [31:0] hoff_w1 [0:15];
    logic [31:0] addr_log [0:63];
    int hoff_cyc, sack_cyc, eoce_cyc, fall_cyc, fin_cyc;
    logic [7:0] last_sack_chan, last_eoce_chan;
    // responder controls
    int ready_delay = 0, wait_cnt = 0;
    logic pend_rd = 1'b0;
    logic [31:0] pend_addr = '0;
    logic fin_req = 1'b0;
    logic [7:0] fin_req_ch = '0;
    logic joint_on = 1'b0;
    logic [3:0] joint_op = '0;
    logic [7:0] joint_ch = '0;
    logic prev_busy = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clr_logs();
        hoff_n = 0; sack_n = 0; eoce_n = 0; both_n = 0; addr_n = 0;
        hoff_cyc = -1; sack_cyc = -1; eoce_cyc = -1; fall_cyc = -1; fin_cyc = -1;
        last_sack_chan = '0; last_eoce_chan = '0;
    endtask

    function automatic logic [31:0] w0(input logic [3:0] op, input bit ack,
                                       input logic [7:0] ch, input bit dev);
        return {15'd0, dev, ch, 3'd0, ack, op};
    endfunction

    task automatic put(input int e, input logic [31:0] a, input logic [31:0] b);
        mem[e] = a; mem[e+1] = b; mem[e+2] = b ^ 32'h0F0F_0000; mem[e+3] = ~b;
    endtask

    // one loop per falling edge: monitor first, then memory and executor models
    initial begin
        clr_logs();
        forever begin
            @(negedge clk);
            ncyc++;
            if (sack) begin sack_n++; sack_cyc = ncyc; last_sack_chan = sack_chan; end
            if (eoce) begin eoce_n++; eoce_cyc = ncyc; last_eoce_chan = eoce_chan; end
            if (sack && eoce) both_n++;
            if (prev_busy && !busy) fall_cyc = ncyc;
            prev_busy = busy;
            // memory model: one cycle latency
            mem_rvalid = 1'b0;
            if (pend_rd) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[pend_addr[9:2]];
                pend_rd    = 1'b0;
            end
            if (mem_req) begin
                pend_rd = 1'b1; pend_addr = mem_addr;
                if (addr_n < 64) addr_log[addr_n] = mem_addr;
                addr_n++;
            end
            // finish reports
            fin_valid = 1'b0;
            if (fin_req) begin
                fin_valid = 1'b1; fin_chan = fin_req_ch; fin_req = 1'b0; fin_cyc = ncyc;
            end
            // executor model
            if (cmd_ready) begin
                cmd_ready = 1'b0;
            end else if (cmd_valid) begin
                if (wait_cnt >= ready_delay) begin
                    cmd_ready = 1'b1;
                    wait_cnt  = 0;
                    hoff_op[hoff_n % 16]   = cmd_op;
                    hoff_chan[hoff_n % 16] = cmd_chan;
                    hoff_dev[hoff_n % 16]  = cmd_dev;
                    hoff_w1[hoff_n % 16]   = cmd_arg[31:0];
                    hoff_n++;
                    hoff_cyc = ncyc;
                    if (joint_on && cmd_op == joint_op) begin
                        fin_valid = 1'b1; fin_chan = joint_ch; joint_on = 1'b0; fin_cyc = ncyc;
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic run_list(input logic [31:0] base, input int cnt);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = base;
        @(negedge clk);
        ptr_we = 1'b0;
        start_we = 1'b1; start_cnt = CNT_W'(cnt);
        @(negedge clk);
        start_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_fin(input logic [7:0] ch);
        fin_req_ch = ch; fin_req = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy, "R11 busy", 32'(busy), 0);
        chk(!err && !sack && !eoce, "R11 pulses", {29'd0, err, sack, eoce}, 0);
        chk(!mem_req && !cmd_valid, "R11 req", {30'd0, mem_req, cmd_valid}, 0);
        chk(ptr_rdata == 0, "R11 ptr", ptr_rdata, 0);
    endtask

    task automatic t_ptr_reg();
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = 32'h0000_0107;
        @(negedge clk); ptr_we = 1'b0;
        chk(ptr_rdata == 32'h100, "R1 readback", ptr_rdata, 32'h100);
    endtask

    task automatic t_list();
        put(64, w0(4'd1, 0, 8'h05, 0), 32'hA0A0_0001);
        put(68, w0(4'd4, 0, 8'h06, 0), 32'hB0B0_0002);
        put(72, w0(4'd2, 1, 8'h22, 1), 32'hC0C0_0003);
        clr_logs(); ready_delay = 0;
        run_list(32'h0000_0107, 3);
        chk(busy, "R9 busy rise", 32'(busy), 1);
        wait_idle();
        chk(addr_n == 12, "R2 read count", 32'(addr_n), 12);
        for (int i = 0; i < 12; i++)
            chk(addr_log[i] == 32'h100 + 32'(4*i), "R2 address", addr_log[i], 32'h100 + 32'(4*i));
        chk(hoff_n == 3, "R3 handoffs", 32'(hoff_n), 3);
        chk(hoff_op[0] == 4'd1 && hoff_chan[0] == 8'h05 && !hoff_dev[0], "R3 entry0",
            {hoff_op[0], hoff_chan[0]}, 32'h105);
        chk(hoff_w1[1] == 32'hB0B0_0002 && hoff_op[1] == 4'd4, "R3 entry1 arg", hoff_w1[1], 32'hB0B0_0002);
        chk(hoff_dev[2] && hoff_chan[2] == 8'h22, "R3 entry2 dev", {hoff_dev[2], hoff_chan[2]}, 32'h122);
        chk(sack_n == 1 && last_sack_chan == 8'h22, "R6 single ack", {sack_n[15:0], 8'h0, last_sack_chan}, 32'h1_0022);
        chk(sack_cyc == hoff_cyc + 1, "R6 ack timing", 32'(sack_cyc), 32'(hoff_cyc + 1));
        chk(fall_cyc == hoff_cyc + 1, "R9 busy fall", 32'(fall_cyc), 32'(hoff_cyc + 1));
    endtask

    task automatic t_nop_bad();
        put(128, w0(4'd0, 1, 8'h09, 0), 32'h1);
        put(132, w0(4'd9, 1, 8'h0A, 0), 32'h2);
        put(136, w0(4'd4, 0, 8'h0B, 0), 32'h3);
        clr_logs();
        run_list(32'h200, 3);
        wait_idle();
        chk(hoff_n == 1 && hoff_chan[0] == 8'h0B, "R4 R5 only bus write handed off",
            {hoff_n[23:0], hoff_chan[0]}, 32'h10B);
        chk(sack_n == 1 && last_sack_chan == 8'h09, "R4 nop ack", {sack_n[23:0], last_sack_chan}, 32'h109);
        chk(err, "R5 err set", 32'(err), 1);
    endtask

    task automatic t_long();
        put(192, w0(4'd5, 1, 8'h03, 0), 32'h5);
        clr_logs(); ready_delay = 3;
        run_list(32'h300, 1);
        chk(!err, "R5 err cleared by start", 32'(err), 0);
        wait_idle();
        chk(sack_n == 1 && last_sack_chan == 8'h03, "R7 early ack", {sack_n[23:0], last_sack_chan}, 32'h103);
        chk(sack_cyc == hoff_cyc + 1, "R7 ack at handoff", 32'(sack_cyc), 32'(hoff_cyc + 1));
        chk(eoce_n == 0, "R7 no eoce yet", 32'(eoce_n), 0);
        send_fin(8'h07);
        chk(eoce_n == 0, "R8 stray finish", 32'(eoce_n), 0);
        send_fin(8'h03);
        chk(eoce_n == 1 && last_eoce_chan == 8'h03, "R7 eoce", {eoce_n[23:0], last_eoce_chan}, 32'h103);
        chk(eoce_cyc == fin_cyc + 1, "R7 eoce timing", 32'(eoce_cyc), 32'(fin_cyc + 1));
        send_fin(8'h03);
        chk(eoce_n == 1, "R8 repeated finish", 32'(eoce_n), 1);
        ready_delay = 0;
    endtask

    task automatic t_joint();
        put(208, w0(4'd6, 0, 8'h04, 0), 32'h6);
        put(212, w0(4'd1, 1, 8'h0C, 0), 32'h7);
        clr_logs();
        joint_op = 4'd1; joint_ch = 8'h04; joint_on = 1'b1;
        run_list(32'h340, 2);
        wait_idle();
        chk(both_n == 1, "R10 same-cycle pulses", 32'(both_n), 1);
        chk(last_sack_chan == 8'h0C && last_eoce_chan == 8'h04, "R10 channels",
            {16'd0, last_sack_chan, last_eoce_chan}, 32'h0C04);
    endtask

    task automatic t_start_rules();
        clr_logs();
        @(negedge clk); start_we = 1'b1; start_cnt = '0;
        @(negedge clk); start_we = 1'b0;
        chk(!busy, "R9 zero count ignored", 32'(busy), 0);
        put(224, w0(4'd3, 0, 8'h01, 0), 32'h8);
        put(228, w0(4'd4, 0, 8'h02, 0), 32'h9);
        put(232, w0(4'd4, 0, 8'h03, 0), 32'hA);
        ready_delay = 20;
        run_list(32'h380, 1);
        repeat (8) @(negedge clk);
        start_we = 1'b1; start_cnt = 8'd3;
        @(negedge clk); start_we = 1'b0;
        wait_idle();
        chk(hoff_n == 1 && hoff_op[0] == 4'd3, "R9 start while busy ignored", 32'(hoff_n), 1);
        chk(sack_n == 0, "R6 no ack when disabled", 32'(sack_n), 0);
        ready_delay = 0;
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_reg();
        t_list();
        t_nop_bad();
        t_long();
        t_joint();
        t_start_rules();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule